// File: doc/BRIEF.md
# Multichannel DMA Register Front End

This block is the memory-mapped register layer that sits in front of a sixteen-channel DMA engine. A 32-bit, word-only bus with a 12-bit offset reaches each channel's status word, its descriptor pointer and a scratch debug word. The same bus gives read-only views of the descriptor that the engine last loaded. Two global registers hold a per-channel interrupt bitmap and a per-channel enable mask. A second select input opens a narrow window that reaches the last channel through offset bits 7:0 alone.

The descriptor fetch and the data mover live outside this block. The engine reports completion, interrupt requests, pause, hold and fault conditions, and freshly loaded descriptor fields on input ports. This block returns a one-cycle start pulse per channel, one interrupt line per channel and the enable mask. Every bus access completes in one cycle. The registered read data and the error flag appear in the cycle after the request.

Top module: `dma_regif`

## Requirements
- R1: After reset, the enable register reads 0x0000FFFF, the interrupt bitmap reads 0, and every channel's status word and descriptor pointer read 0. All interrupt lines are low and all enable outputs are high.
- R2: With the narrow select low, offsets below 0xF00 address channel offset[11:8] and register offset[7:0]. With the narrow select high, channel 15 is addressed and offset[11:8] is ignored. Read data and the error flag are registered and appear one cycle after the request.
- R3: The descriptor pointer (register offset 0x04) and the debug word (0x20) are 32-bit read/write registers.
- R4: The status word (0x00) stores the written value ANDed with 0x30FF0001, where bit 0 is the run bit. It reports the end flag in bit 1, the interrupt flag in bit 2, paused_i in bit 4, held_i in bit 5 and fault_i in bit 8. Bits 30 and 31 read as zero.
- R5: Writing 1 to status bit 1 clears the end flag. Writing 1 to status bit 2 clears the interrupt flag, the channel's bit in the bitmap and the channel's interrupt line.
- R6: A status write that takes the run bit from 0 to 1 produces a single-cycle start_o pulse for that channel in the cycle after the write. Writing 1 while the bit is already 1 produces no pulse.
- R7: A done_i pulse sets the end flag, clears the run bit and copies the next-descriptor field into the descriptor pointer. An irq_set_i pulse sets the interrupt flag, the bitmap bit and the interrupt line.
- R8: A desc_ld_i pulse loads six fields into channel desc_ch_i. These fields read at 0x08 (info), 0x0C (source), 0x10 (destination), 0x14 (length), 0x18 (stride) and 0x1C (next). Bus writes to these offsets change nothing and raise the error flag.
- R9: Offset 0xFE0 reads the interrupt bitmap, with channel n in bit n; a write there changes nothing and raises no error. Offset 0xFF0 is the enable register; a write keeps bits 15:0, which drive chan_en_o.
- R10: An access to an undecoded offset or a misaligned offset returns 0 on a read and has no effect on a write. It raises err_o for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| hi_sel_i | input | 1 | Selects the narrow window for channel 15 |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Registered decode-error pulse |
| done_i | input | 16 | Per-channel completion pulse from the engine |
| irq_set_i | input | 16 | Per-channel interrupt request from the engine |
| paused_i | input | 16 | Per-channel paused condition |
| held_i | input | 16 | Per-channel flow-control hold condition |
| fault_i | input | 16 | Per-channel error condition |
| desc_ld_i | input | 1 | Load strobe for descriptor fields |
| desc_ch_i | input | 4 | Channel receiving the descriptor |
| desc_info_i | input | 32 | Descriptor info word |
| desc_src_i | input | 32 | Descriptor source address |
| desc_dst_i | input | 32 | Descriptor destination address |
| desc_len_i | input | 32 | Descriptor length |
| desc_stride_i | input | 32 | Descriptor stride |
| desc_next_i | input | 32 | Next-descriptor address |
| start_o | output | 16 | Per-channel start pulse |
| irq_o | output | 16 | Per-channel interrupt line |
| chan_en_o | output | 16 | Per-channel enable mask |

## Verification
The status word is exercised with an all-ones write that leaves the run bit clear, which separates the stored mask bits from the flag bits and from the command bits that read as zero. It is then exercised with run-bit writes from the idle and the running state, which separates a start on the edge from a start on the level. Engine completion and interrupt pulses are followed by write-one-to-clear writes. These show that the flags, the bitmap and the interrupt line move together, and that the descriptor pointer follows the next field. Address patterns cover both windows, the ignored channel bits in the narrow window, the read-only descriptor offsets, the two global offsets, and misaligned and out-of-range offsets. Together they tell a correct decode apart from an aliased or overly permissive one.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 12;
  localparam int unsigned CH_IDX_W = 4;

  localparam logic [DW-1:0] CS_WR_MASK = 32'h30FF_0001;
  localparam int unsigned   CS_RUN   = 0;
  localparam int unsigned   CS_END   = 1;
  localparam int unsigned   CS_INT   = 2;
  localparam int unsigned   CS_PAUSE = 4;
  localparam int unsigned   CS_HOLD  = 5;
  localparam int unsigned   CS_FAULT = 8;

  localparam logic [AW-1:0] CH_LIMIT = 12'hF00;
  localparam logic [AW-1:0] G_INT    = 12'hFE0;
  localparam logic [AW-1:0] G_EN     = 12'hFF0;

  typedef enum logic [3:0] {
    RG_CS     = 4'd0,
    RG_CB     = 4'd1,
    RG_INFO   = 4'd2,
    RG_SRC    = 4'd3,
    RG_DST    = 4'd4,
    RG_LEN    = 4'd5,
    RG_STRIDE = 4'd6,
    RG_NEXT   = 4'd7,
    RG_DBG    = 4'd8
  } reg_e;

  typedef struct packed {
    logic                ch_hit;
    logic [CH_IDX_W-1:0] ch;
    reg_e                rg;
    logic                g_int;
    logic                g_en;
    logic                bad;
  } dec_t;
endpackage

// File: rtl/dma_regif_decode.sv
module dma_regif_decode
  import dma_regif_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic          hi_sel_i,
  input  logic          we_i,
  output dec_t          dec_o
);
  logic [5:0] word;
  logic       reg_ok;
  logic       ro;

  assign word   = addr_i[7:2];
  assign reg_ok = (addr_i[1:0] == 2'b00) && (word <= 6'd8);

  always_comb begin
    dec_o       = '0;
    dec_o.rg    = reg_ok ? reg_e'(word[3:0]) : RG_CS;
    if (hi_sel_i) begin
      dec_o.ch     = CH_IDX_W'(NUM_CH - 1);
      dec_o.ch_hit = reg_ok;
    end else if (addr_i < CH_LIMIT) begin
      dec_o.ch     = addr_i[11:8];
      dec_o.ch_hit = reg_ok && (32'(addr_i[11:8]) < NUM_CH);
    end else begin
      dec_o.g_int = (addr_i == G_INT);
      dec_o.g_en  = (addr_i == G_EN);
    end
    ro        = (dec_o.rg != RG_CS) && (dec_o.rg != RG_CB) && (dec_o.rg != RG_DBG);
    dec_o.bad = !((dec_o.ch_hit && !(we_i && ro)) || dec_o.g_int || dec_o.g_en);
  end
endmodule

// File: rtl/dma_regif_chan.sv
module dma_regif_chan
  import dma_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_e          rg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  input  logic          irq_set_i,
  input  logic          paused_i,
  input  logic          held_i,
  input  logic          fault_i,
  input  logic          desc_ld_i,
  input  logic [DW-1:0] desc_info_i,
  input  logic [DW-1:0] desc_src_i,
  input  logic [DW-1:0] desc_dst_i,
  input  logic [DW-1:0] desc_len_i,
  input  logic [DW-1:0] desc_stride_i,
  input  logic [DW-1:0] desc_next_i,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] dbg_o,
  output logic [DW-1:0] info_o,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [DW-1:0] len_o,
  output logic [DW-1:0] stride_o,
  output logic [DW-1:0] next_o,
  output logic          irq_o,
  output logic          start_o
);
  logic [DW-1:0] fld_q;
  logic          end_q, int_q, start_q;
  logic          wr_cs;

  assign wr_cs = wr_i && (rg_i == RG_CS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q    <= '0;
      end_q    <= 1'b0;
      int_q    <= 1'b0;
      start_q  <= 1'b0;
      cb_o     <= '0;
      dbg_o    <= '0;
      info_o   <= '0;
      src_o    <= '0;
      dst_o    <= '0;
      len_o    <= '0;
      stride_o <= '0;
      next_o   <= '0;
    end else begin
      start_q <= wr_cs && wdata_i[CS_RUN] && !fld_q[CS_RUN];
      // engine events first; a same-cycle bus write takes priority
      if (done_i) begin
        end_q         <= 1'b1;
        fld_q[CS_RUN] <= 1'b0;
        cb_o          <= next_o;
      end
      if (irq_set_i) int_q <= 1'b1;
      if (wr_cs) begin
        if (wdata_i[CS_END]) end_q <= 1'b0;
        if (wdata_i[CS_INT]) int_q <= 1'b0;
        fld_q <= wdata_i & CS_WR_MASK;
      end
      if (wr_i && rg_i == RG_CB)  cb_o  <= wdata_i;
      if (wr_i && rg_i == RG_DBG) dbg_o <= wdata_i;
      if (desc_ld_i) begin
        info_o   <= desc_info_i;
        src_o    <= desc_src_i;
        dst_o    <= desc_dst_i;
        len_o    <= desc_len_i;
        stride_o <= desc_stride_i;
        next_o   <= desc_next_i;
      end
    end
  end

  always_comb begin
    cs_o           = fld_q;
    cs_o[CS_END]   = end_q;
    cs_o[CS_INT]   = int_q;
    cs_o[CS_PAUSE] = paused_i;
    cs_o[CS_HOLD]  = held_i;
    cs_o[CS_FAULT] = fault_i;
  end

  assign irq_o   = int_q;
  assign start_o = start_q;

  p_start_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_cs && wdata_i[CS_RUN]));
  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_set_i));
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_cs) |=> !cs_o[CS_RUN]);
  p_int_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cs && wdata_i[CS_INT]) |=> !irq_o);
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                hi_sel_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                err_o,
  input  logic [NUM_CH-1:0]   done_i,
  input  logic [NUM_CH-1:0]   irq_set_i,
  input  logic [NUM_CH-1:0]   paused_i,
  input  logic [NUM_CH-1:0]   held_i,
  input  logic [NUM_CH-1:0]   fault_i,
  input  logic                desc_ld_i,
  input  logic [CH_IDX_W-1:0] desc_ch_i,
  input  logic [DW-1:0]       desc_info_i,
  input  logic [DW-1:0]       desc_src_i,
  input  logic [DW-1:0]       desc_dst_i,
  input  logic [DW-1:0]       desc_len_i,
  input  logic [DW-1:0]       desc_stride_i,
  input  logic [DW-1:0]       desc_next_i,
  output logic [NUM_CH-1:0]   start_o,
  output logic [NUM_CH-1:0]   irq_o,
  output logic [NUM_CH-1:0]   chan_en_o
);
  dec_t          dec;
  logic [DW-1:0] rd_d;
  logic [NUM_CH-1:0] en_q;
  logic [DW-1:0] cs_v [NUM_CH];
  logic [DW-1:0] cb_v [NUM_CH];
  logic [DW-1:0] dbg_v [NUM_CH];
  logic [DW-1:0] info_v [NUM_CH];
  logic [DW-1:0] src_v [NUM_CH];
  logic [DW-1:0] dst_v [NUM_CH];
  logic [DW-1:0] len_v [NUM_CH];
  logic [DW-1:0] stride_v [NUM_CH];
  logic [DW-1:0] next_v [NUM_CH];

  dma_regif_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i   (addr_i),
    .hi_sel_i (hi_sel_i),
    .we_i     (we_i),
    .dec_o    (dec)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr;
    assign wr = req_i && we_i && !dec.bad && dec.ch_hit && (dec.ch == CH_IDX_W'(i));
    dma_regif_chan u_ch (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_i          (wr),
      .rg_i          (dec.rg),
      .wdata_i       (wdata_i),
      .done_i        (done_i[i]),
      .irq_set_i     (irq_set_i[i]),
      .paused_i      (paused_i[i]),
      .held_i        (held_i[i]),
      .fault_i       (fault_i[i]),
      .desc_ld_i     (desc_ld_i && (desc_ch_i == CH_IDX_W'(i))),
      .desc_info_i   (desc_info_i),
      .desc_src_i    (desc_src_i),
      .desc_dst_i    (desc_dst_i),
      .desc_len_i    (desc_len_i),
      .desc_stride_i (desc_stride_i),
      .desc_next_i   (desc_next_i),
      .cs_o          (cs_v[i]),
      .cb_o          (cb_v[i]),
      .dbg_o         (dbg_v[i]),
      .info_o        (info_v[i]),
      .src_o         (src_v[i]),
      .dst_o         (dst_v[i]),
      .len_o         (len_v[i]),
      .stride_o      (stride_v[i]),
      .next_o        (next_v[i]),
      .irq_o         (irq_o[i]),
      .start_o       (start_o[i])
    );
  end

  always_comb begin
    rd_d = '0;
    if (dec.bad) begin
      rd_d = '0;
    end else if (dec.g_int) begin
      rd_d = DW'(irq_o);
    end else if (dec.g_en) begin
      rd_d = DW'(en_q);
    end else begin
      case (dec.rg)
        RG_CS:     rd_d = cs_v[dec.ch];
        RG_CB:     rd_d = cb_v[dec.ch];
        RG_INFO:   rd_d = info_v[dec.ch];
        RG_SRC:    rd_d = src_v[dec.ch];
        RG_DST:    rd_d = dst_v[dec.ch];
        RG_LEN:    rd_d = len_v[dec.ch];
        RG_STRIDE: rd_d = stride_v[dec.ch];
        RG_NEXT:   rd_d = next_v[dec.ch];
        RG_DBG:    rd_d = dbg_v[dec.ch];
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '1;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= (req_i && !we_i) ? rd_d : '0;
      err_o   <= req_i && dec.bad;
      if (req_i && we_i && dec.g_en) en_q <= wdata_i[NUM_CH-1:0];
    end
  end

  assign chan_en_o = en_q;

  p_err_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));
  p_err_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  p_en_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && we_i) |-> $stable(chan_en_o));
endmodule

// File: tb/dma_regif_tb_top.sv
`timescale 1ns/1ps
module dma_regif_tb_top;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, we = 0, hi = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;
  logic [NCH-1:0] done = '0, irq_set = '0, paused = '0, held = '0, fault = '0;
  logic desc_ld = 0;
  logic [3:0] desc_ch = '0;
  logic [31:0] d_info = '0, d_src = '0, d_dst = '0, d_len = '0, d_stride = '0, d_next = '0;
  logic [NCH-1:0] start, irq, chan_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] got_rd;
  logic got_err;
  logic [NCH-1:0] got_start;

  always #2.5 clk = ~clk;

  dma_regif #(.NUM_CH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .hi_sel_i(hi),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .done_i(done), .irq_set_i(irq_set), .paused_i(paused), .held_i(held),
    .fault_i(fault), .desc_ld_i(desc_ld), .desc_ch_i(desc_ch),
    .desc_info_i(d_info), .desc_src_i(d_src), .desc_dst_i(d_dst),
    .desc_len_i(d_len), .desc_stride_i(d_stride), .desc_next_i(d_next),
    .start_o(start), .irq_o(irq), .chan_en_o(chan_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bus(input logic h, input logic w, input logic [11:0] a, input logic [31:0] d);
    req = 1; we = w; hi = h; addr = a; wdata = d;
    @(negedge clk);
    got_rd = rdata; got_err = err; got_start = start;
    req = 0; we = 0; hi = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq lines", 32'(irq), 0);
    chk("R1 enable outputs", 32'(chan_en), 32'hFFFF);
    bus(0, 0, 12'hFF0, 0); chk("R1 enable reg", got_rd, 32'h0000FFFF);
    bus(0, 0, 12'hFE0, 0); chk("R1 int bitmap", got_rd, 0);
    bus(0, 0, 12'h300, 0); chk("R1 status ch3", got_rd, 0);
    bus(0, 0, 12'h304, 0); chk("R1 pointer ch3", got_rd, 0);
  endtask

  task automatic t_decode;
    bus(0, 1, 12'h004, 32'h1000);
    bus(0, 1, 12'h504, 32'h2000);
    bus(0, 1, 12'hE20, 32'hDEADBEEF);
    bus(1, 1, 12'h004, 32'h3000);
    bus(0, 0, 12'h004, 0); chk("R3 ch0 pointer", got_rd, 32'h1000);
    bus(0, 0, 12'h504, 0); chk("R2 ch5 pointer", got_rd, 32'h2000);
    bus(0, 0, 12'hE20, 0); chk("R3 ch14 debug", got_rd, 32'hDEADBEEF);
    bus(1, 0, 12'h004, 0); chk("R2 narrow ch15 pointer", got_rd, 32'h3000);
    bus(1, 0, 12'h904, 0); chk("R2 narrow ignores 11:8", got_rd, 32'h3000);
    bus(0, 0, 12'h104, 0); chk("R2 ch1 untouched", got_rd, 0);
    bus(0, 0, 12'hF04, 0);
    chk("R2 main window stops below F00 err", 32'(got_err), 1);
    chk("R2 main window stops below F00 data", got_rd, 0);
  endtask

  task automatic t_mask;
    bus(0, 1, 12'h200, 32'hFFFF_FFFE);
    chk("R4 no start when run bit 0", 32'(got_start), 0);
    bus(0, 0, 12'h200, 0); chk("R4 masked status", got_rd, 32'h30FF0000);
    paused[2] = 1; held[2] = 1; fault[2] = 1;
    bus(0, 0, 12'h200, 0); chk("R4 condition bits", got_rd, 32'h30FF0130);
    paused = '0; held = '0; fault = '0;
  endtask

  task automatic t_desc;
    desc_ch = 4'd2; d_info = 32'h11; d_src = 32'h22; d_dst = 32'h33;
    d_len = 32'h44; d_stride = 32'h55; d_next = 32'hABC0; desc_ld = 1;
    @(negedge clk);
    desc_ld = 0;
    bus(0, 0, 12'h208, 0); chk("R8 info", got_rd, 32'h11);
    bus(0, 0, 12'h20C, 0); chk("R8 source", got_rd, 32'h22);
    bus(0, 0, 12'h210, 0); chk("R8 dest", got_rd, 32'h33);
    bus(0, 0, 12'h214, 0); chk("R8 length", got_rd, 32'h44);
    bus(0, 0, 12'h218, 0); chk("R8 stride", got_rd, 32'h55);
    bus(0, 0, 12'h21C, 0); chk("R8 next", got_rd, 32'hABC0);
    bus(0, 0, 12'h31C, 0); chk("R8 other channel", got_rd, 0);
    bus(0, 1, 12'h208, 32'hFFFF); chk("R8 ro write err", 32'(got_err), 1);
    bus(0, 0, 12'h208, 0); chk("R8 ro write ignored", got_rd, 32'h11);
  endtask

  task automatic t_start;
    bus(0, 1, 12'h200, 32'h1);
    chk("R6 start pulse", 32'(got_start), 32'h0004);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(start), 0);
    bus(0, 1, 12'h200, 32'h1);
    chk("R6 no start when running", 32'(got_start), 0);
    bus(0, 0, 12'h200, 0); chk("R6 run bit", got_rd, 32'h1);
    bus(1, 1, 12'h000, 32'h1);
    chk("R6 narrow ch15 start", 32'(got_start), 32'h8000);
  endtask

  task automatic t_done;
    done[2] = 1; irq_set[2] = 1;
    @(negedge clk);
    done = '0; irq_set = '0;
    chk("R7 irq line", 32'(irq), 32'h0004);
    bus(0, 0, 12'hFE0, 0); chk("R7 bitmap", got_rd, 32'h4);
    bus(0, 0, 12'h200, 0); chk("R7 status after done", got_rd, 32'h6);
    bus(0, 0, 12'h204, 0); chk("R7 pointer follows next", got_rd, 32'hABC0);
  endtask

  task automatic t_w1c;
    bus(0, 1, 12'h200, 32'h4);
    chk("R5 irq dropped", 32'(irq), 0);
    bus(0, 0, 12'hFE0, 0); chk("R5 bitmap cleared", got_rd, 0);
    bus(0, 0, 12'h200, 0); chk("R5 end kept", got_rd, 32'h2);
    bus(0, 1, 12'h200, 32'h2);
    bus(0, 0, 12'h200, 0); chk("R5 end cleared", got_rd, 0);
  endtask

  task automatic t_global;
    irq_set[5] = 1;
    @(negedge clk);
    irq_set = '0;
    bus(0, 1, 12'hFE0, 32'hFFFF_FFFF); chk("R9 bitmap write no err", 32'(got_err), 0);
    bus(0, 0, 12'hFE0, 0); chk("R9 bitmap write ignored", got_rd, 32'h20);
    bus(0, 1, 12'hFF0, 32'h1234_5A5A); chk("R9 enable write no err", 32'(got_err), 0);
    bus(0, 0, 12'hFF0, 0); chk("R9 enable low bits", got_rd, 32'h5A5A);
    chk("R9 enable outputs", 32'(chan_en), 32'h5A5A);
  endtask

  task automatic t_bad;
    bus(0, 0, 12'h024, 0);
    chk("R10 undecoded err", 32'(got_err), 1);
    chk("R10 undecoded read zero", got_rd, 0);
    bus(0, 0, 12'h004, 0); chk("R10 err one cycle", 32'(got_err), 0);
    bus(0, 0, 12'h006, 0); chk("R10 misaligned err", 32'(got_err), 1);
    bus(0, 1, 12'hF80, 32'h77); chk("R10 global hole err", 32'(got_err), 1);
    bus(0, 1, 12'h106, 32'h77); chk("R10 misaligned write err", 32'(got_err), 1);
    bus(0, 0, 12'h104, 0); chk("R10 write had no effect", got_rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_mask();
    t_desc();
    t_start();
    t_done();
    t_w1c();
    t_global();
    t_bad();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule